// File: doc/BRIEF.md
# Dual-Port RAM with Contention Busy

A synchronous two-port word memory for a large chip. Left and right ports are fully independent: each has its own active-low enable, read/write select, active-low output enable, active-low semaphore select, address, write data, read data and a data-valid flag that stands in for a tri-state output driver. Both ports may read any word in the same cycle, including the same word. Semaphore cycles (semaphore select low) are not handled here and leave the array untouched.

When both ports touch the same word in one cycle and at least one of them writes, an arbiter picks a winner. The port that was already on that word in the previous cycle wins; if both arrive together, the left port wins. The losing port's write is dropped and its busy flag rises in the next cycle. A master strap selects the busy source. When the strap is high, busy comes from this arbiter. When it is low, the block acts as a cascaded slave: its busy outputs stay low and each port's writes are blocked by a busy input from the master device. Several devices then form a wider word. The full 32768 x 8 size is reached with `ADDR_W = 15`. The default is kept small.

Top module: `dp_ram_busy`

## Requirements
- R1: A port with enable low, semaphore select high and read/write select low (write) stores its write data at its address on the clock edge.
- R2: A port with enable low, semaphore select high, read/write select high and output enable low (read) shows the stored word on its read data with valid high, one cycle after the request.
- R3: A port with enable high, or with semaphore select low, does not change the array, and its valid stays low with read data zero.
- R4: With output enable high, valid is low and read data is zero in the following cycle, whatever the other controls are.
- R5: Both ports reading the same word in one cycle both return that word.
- R6: A read and a write of the same word in one cycle return the word as it was before that write.
- R7: In master mode, when both ports newly reach the same word in one cycle and at least one writes, the left port wins. The right port's write is dropped, and right busy is high in the next cycle while left busy stays low.
- R8: In master mode, a port that already held a word in the previous cycle wins against a port that newly reaches it. The newcomer's write is dropped and its busy rises.
- R9: Busy is low in the first cycle after the overlap ends. No busy is raised for different addresses or for two reads of one word.
- R10: With the master strap low, both busy outputs stay low and no arbitration takes place. A port's write is dropped exactly when its busy input is high.
- R11: After reset both valid flags and both busy outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1: busy produced locally, 0: busy taken from inputs |
| l_en_n_i | input | 1 | Left enable, active low |
| l_rd_wr_i | input | 1 | Left 1 = read, 0 = write |
| l_oe_n_i | input | 1 | Left output enable, active low |
| l_sem_n_i | input | 1 | Left semaphore select, active low |
| l_addr_i | input | ADDR_W | Left address |
| l_wdata_i | input | DATA_W | Left write data |
| l_rdata_o | output | DATA_W | Left read data, zero when not valid |
| l_rvalid_o | output | 1 | Left output driven |
| l_busy_i | input | 1 | Left write block from master (slave mode) |
| l_busy_o | output | 1 | Left busy (master mode) |
| r_en_n_i | input | 1 | Right enable, active low |
| r_rd_wr_i | input | 1 | Right 1 = read, 0 = write |
| r_oe_n_i | input | 1 | Right output enable, active low |
| r_sem_n_i | input | 1 | Right semaphore select, active low |
| r_addr_i | input | ADDR_W | Right address |
| r_wdata_i | input | DATA_W | Right write data |
| r_rdata_o | output | DATA_W | Right read data, zero when not valid |
| r_rvalid_o | output | 1 | Right output driven |
| r_busy_i | input | 1 | Right write block from master (slave mode) |
| r_busy_o | output | 1 | Right busy (master mode) |

## Verification
The assertions watch the busy pair on every cycle. They check that both flags are never high together and that busy only follows a cycle with a real overlap. They also check that busy drops after an overlap-free cycle and stays quiet in slave mode, and that valid never follows a cycle with output enable high. The contents of the array can only be shown by the bench's scenarios. These cover dropped writes and read-before-write data, the left-on-tie and first-arrival orders, and the blocking of writes by the busy inputs.

// File: rtl/dp_ram_pkg.sv
package dp_ram_pkg;
  localparam int unsigned NPORT = 2;
  localparam int unsigned P_L = 0;
  localparam int unsigned P_R = 1;

  typedef enum logic {
    WIN_LEFT  = 1'b0,
    WIN_RIGHT = 1'b1
  } win_e;
endpackage

// File: rtl/dp_port_dec.sv
module dp_port_dec #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_n_i,
  input  logic              rd_wr_i,
  input  logic              oe_n_i,
  input  logic              sem_n_i,
  input  logic [DATA_W-1:0] core_rdata_i,
  output logic              act_o,
  output logic              wr_o,
  output logic              rd_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  logic rvalid_q;

  // memory cycle only with enable low and semaphore select idle
  assign act_o = ~en_n_i & sem_n_i;
  assign wr_o  = act_o & ~rd_wr_i;
  assign rd_o  = act_o & rd_wr_i & ~oe_n_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rvalid_q <= 1'b0;
    else         rvalid_q <= rd_o;
  end

  assign rvalid_o = rvalid_q;
  assign rdata_o  = rvalid_q ? core_rdata_i : '0;

  // R4
  oe_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_n_i |=> !rvalid_o);
endmodule

// File: rtl/dp_mem_core.sv
module dp_mem_core #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8
) (
  input  logic                   clk_i,
  input  logic [1:0]             we_i,
  input  logic [1:0]             re_i,
  input  logic [1:0][ADDR_W-1:0] addr_i,
  input  logic [1:0][DATA_W-1:0] wdata_i,
  output logic [1:0][DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [1:0][DATA_W-1:0] rdata_q;

  // read-first: nonblocking reads see the word before this edge's write
  always_ff @(posedge clk_i) begin
    for (int p = 0; p < 2; p++) begin
      if (re_i[p]) rdata_q[p] <= mem_q[addr_i[p]];
      if (we_i[p]) mem_q[addr_i[p]] <= wdata_i[p];
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/dp_arbiter.sv
module dp_arbiter
  import dp_ram_pkg::*;
#(
  parameter int unsigned ADDR_W = 11
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   master_i,
  input  logic [1:0]             act_i,
  input  logic [1:0]             wr_i,
  input  logic [1:0][ADDR_W-1:0] addr_i,
  input  logic [1:0]             busy_ext_i,
  output logic [1:0]             we_o,
  output logic [1:0]             busy_o
);
  logic [1:0][ADDR_W-1:0] prev_addr_q;
  logic [1:0]             prev_act_q;
  logic [1:0]             stay;
  logic [1:0]             lose;
  logic [1:0]             blk;
  logic [1:0]             busy_q;
  logic                   clash, clash_q;
  win_e                   win_d, win_q;

  assign clash = act_i[P_L] & act_i[P_R] & (addr_i[P_L] == addr_i[P_R])
               & (wr_i[P_L] | wr_i[P_R]);

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign stay[p] = act_i[p] & prev_act_q[p] & (prev_addr_q[p] == addr_i[p]);
    assign blk[p]  = master_i ? lose[p] : busy_ext_i[p];
    assign we_o[p] = wr_i[p] & ~blk[p];
  end

  // winner fixed for the whole overlap; earlier arrival first, else left
  always_comb begin
    if (clash_q)                         win_d = win_q;
    else if (stay[P_R] && !stay[P_L])    win_d = WIN_RIGHT;
    else                                 win_d = WIN_LEFT;
  end

  assign lose[P_L] = clash & (win_d == WIN_RIGHT);
  assign lose[P_R] = clash & (win_d == WIN_LEFT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_addr_q <= '0;
      prev_act_q  <= '0;
      clash_q     <= 1'b0;
      win_q       <= WIN_LEFT;
      busy_q      <= '0;
    end else begin
      prev_addr_q <= addr_i;
      prev_act_q  <= act_i;
      clash_q     <= clash;
      win_q       <= win_d;
      busy_q      <= master_i ? lose : 2'b00;
    end
  end

  assign busy_o = busy_q;

  // R7
  one_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o[P_L] && busy_o[P_R]));
  // R8
  busy_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o != 2'b00) |-> $past(act_i == 2'b11 && addr_i[P_L] == addr_i[P_R]));
  // R9
  busy_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clash |=> (busy_o == 2'b00));
  // R10
  slave_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |=> (busy_o == 2'b00));
endmodule

// File: rtl/dp_ram_busy.sv
module dp_ram_busy
  import dp_ram_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_i,
  input  logic              l_en_n_i,
  input  logic              l_rd_wr_i,
  input  logic              l_oe_n_i,
  input  logic              l_sem_n_i,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic [DATA_W-1:0] l_wdata_i,
  output logic [DATA_W-1:0] l_rdata_o,
  output logic              l_rvalid_o,
  input  logic              l_busy_i,
  output logic              l_busy_o,
  input  logic              r_en_n_i,
  input  logic              r_rd_wr_i,
  input  logic              r_oe_n_i,
  input  logic              r_sem_n_i,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic [DATA_W-1:0] r_wdata_i,
  output logic [DATA_W-1:0] r_rdata_o,
  output logic              r_rvalid_o,
  input  logic              r_busy_i,
  output logic              r_busy_o
);
  logic [1:0]             en_n, rd_wr, oe_n, sem_n;
  logic [1:0]             act, wr, rd, we, busy;
  logic [1:0][ADDR_W-1:0] addr;
  logic [1:0][DATA_W-1:0] wdata, core_rdata, rdata;
  logic [1:0]             rvalid;

  assign en_n  = {r_en_n_i,  l_en_n_i};
  assign rd_wr = {r_rd_wr_i, l_rd_wr_i};
  assign oe_n  = {r_oe_n_i,  l_oe_n_i};
  assign sem_n = {r_sem_n_i, l_sem_n_i};
  assign addr  = {r_addr_i,  l_addr_i};
  assign wdata = {r_wdata_i, l_wdata_i};

  for (genvar p = 0; p < NPORT; p++) begin : g_dec
    dp_port_dec #(.DATA_W(DATA_W)) u_dec (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .en_n_i      (en_n[p]),
      .rd_wr_i     (rd_wr[p]),
      .oe_n_i      (oe_n[p]),
      .sem_n_i     (sem_n[p]),
      .core_rdata_i(core_rdata[p]),
      .act_o       (act[p]),
      .wr_o        (wr[p]),
      .rd_o        (rd[p]),
      .rdata_o     (rdata[p]),
      .rvalid_o    (rvalid[p])
    );
  end

  dp_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .master_i  (master_i),
    .act_i     (act),
    .wr_i      (wr),
    .addr_i    (addr),
    .busy_ext_i({r_busy_i, l_busy_i}),
    .we_o      (we),
    .busy_o    (busy)
  );

  dp_mem_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_core (
    .clk_i  (clk_i),
    .we_i   (we),
    .re_i   (rd),
    .addr_i (addr),
    .wdata_i(wdata),
    .rdata_o(core_rdata)
  );

  assign l_rdata_o  = rdata[P_L];
  assign r_rdata_o  = rdata[P_R];
  assign l_rvalid_o = rvalid[P_L];
  assign r_rvalid_o = rvalid[P_R];
  assign l_busy_o   = busy[P_L];
  assign r_busy_o   = busy[P_R];

  // R3
  desel_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_en_n_i || !l_sem_n_i) |-> !we[P_L]);
endmodule

// File: tb/dp_ram_busy_tb.sv
module dp_ram_busy_tb;
  localparam int unsigned AW = 11;
  localparam int unsigned DW = 8;

  typedef enum int {OP_IDLE, OP_WR, OP_RD, OP_RD_NOOE, OP_WR_DESEL, OP_WR_SEM} op_e;

  localparam logic [AW-1:0] TA [8] = '{11'h000, 11'h001, 11'h2AA, 11'h555,
                                      11'h7FF, 11'h123, 11'h400, 11'h0F0};
  localparam logic [DW-1:0] TD [8] = '{8'h00, 8'hFF, 8'hA5, 8'h5A,
                                      8'h81, 8'h3C, 8'h7E, 8'hC3};

  logic clk = 1'b0, rst_n = 1'b0, master = 1'b1;
  logic l_en_n, l_rd_wr, l_oe_n, l_sem_n, l_busy_in, l_rvalid, l_busy;
  logic r_en_n, r_rd_wr, r_oe_n, r_sem_n, r_busy_in, r_rvalid, r_busy;
  logic [AW-1:0] l_addr, r_addr;
  logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dp_ram_busy #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .master_i(master),
    .l_en_n_i(l_en_n), .l_rd_wr_i(l_rd_wr), .l_oe_n_i(l_oe_n), .l_sem_n_i(l_sem_n),
    .l_addr_i(l_addr), .l_wdata_i(l_wdata), .l_rdata_o(l_rdata), .l_rvalid_o(l_rvalid),
    .l_busy_i(l_busy_in), .l_busy_o(l_busy),
    .r_en_n_i(r_en_n), .r_rd_wr_i(r_rd_wr), .r_oe_n_i(r_oe_n), .r_sem_n_i(r_sem_n),
    .r_addr_i(r_addr), .r_wdata_i(r_wdata), .r_rdata_o(r_rdata), .r_rvalid_o(r_rvalid),
    .r_busy_i(r_busy_in), .r_busy_o(r_busy)
  );

  task automatic set_port(input bit right, input op_e op, input logic [AW-1:0] a,
                          input logic [DW-1:0] d);
    logic en_n, rw, oe_n, sem_n;
    en_n = 1'b0; rw = 1'b1; oe_n = 1'b0; sem_n = 1'b1;
    case (op)
      OP_IDLE:     begin en_n = 1'b1; oe_n = 1'b1; end
      OP_WR:       rw = 1'b0;
      OP_RD:       ;
      OP_RD_NOOE:  oe_n = 1'b1;
      OP_WR_DESEL: begin en_n = 1'b1; rw = 1'b0; end
      OP_WR_SEM:   begin rw = 1'b0; sem_n = 1'b0; end
      default:     ;
    endcase
    if (right) begin
      r_en_n = en_n; r_rd_wr = rw; r_oe_n = oe_n; r_sem_n = sem_n; r_addr = a; r_wdata = d;
    end else begin
      l_en_n = en_n; l_rd_wr = rw; l_oe_n = oe_n; l_sem_n = sem_n; l_addr = a; l_wdata = d;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    set_port(1'b0, OP_IDLE, '0, '0);
    set_port(1'b1, OP_IDLE, '0, '0);
  endtask

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic read_both(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    set_port(1'b0, OP_RD, a, '0);
    set_port(1'b1, OP_IDLE, '0, '0);
    tick();
    chk(tag, l_rdata, exp);
    idle();
    tick();
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    l_busy_in = 1'b0; r_busy_in = 1'b0;
    idle();
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    chk("R11 l_rvalid", {7'd0, l_rvalid}, 8'd0);
    chk("R11 r_rvalid", {7'd0, r_rvalid}, 8'd0);
    chk("R11 busy", {6'd0, l_busy, r_busy}, 8'd0);
    rst_n = 1'b1;
    tick();

    // R1 table writes through left
    for (int i = 0; i < 8; i++) begin
      set_port(1'b0, OP_WR, TA[i], TD[i]);
      tick();
    end
    idle();
    tick();
    // R2 table reads through right, one cycle latency
    for (int i = 0; i < 8; i++) begin
      set_port(1'b1, OP_RD, TA[i], '0);
      tick();
      chk("R2 r_rdata", r_rdata, TD[i]);
      chk("R2 r_rvalid", {7'd0, r_rvalid}, 8'd1);
    end
    idle();
    tick();

    // R5 both read the same word
    set_port(1'b0, OP_RD, TA[2], '0);
    set_port(1'b1, OP_RD, TA[2], '0);
    tick();
    chk("R5 l_rdata", l_rdata, TD[2]);
    chk("R5 r_rdata", r_rdata, TD[2]);
    chk("R9 no busy on two reads", {6'd0, l_busy, r_busy}, 8'd0);
    idle();
    tick();

    // R3 deselected and semaphore writes leave array alone
    set_port(1'b0, OP_WR_DESEL, TA[3], 8'hEE);
    tick();
    chk("R3 desel rvalid", {7'd0, l_rvalid}, 8'd0);
    chk("R3 desel rdata", l_rdata, 8'd0);
    set_port(1'b0, OP_WR_SEM, TA[3], 8'hDD);
    tick();
    chk("R3 sem rvalid", {7'd0, l_rvalid}, 8'd0);
    idle();
    tick();
    read_both(TA[3], TD[3], "R3 word kept");

    // R4 output enable high blocks read data
    set_port(1'b0, OP_RD_NOOE, TA[4], '0);
    tick();
    chk("R4 rvalid", {7'd0, l_rvalid}, 8'd0);
    chk("R4 rdata", l_rdata, 8'd0);
    idle();
    tick();

    // R6 + R7: left writes, right reads same word, both new
    set_port(1'b0, OP_WR, TA[5], 8'h99);
    set_port(1'b1, OP_RD, TA[5], '0);
    tick();
    chk("R6 old data", r_rdata, TD[5]);
    chk("R7 r_busy", {7'd0, r_busy}, 8'd1);
    chk("R7 l_busy", {7'd0, l_busy}, 8'd0);
    idle();
    tick();
    chk("R9 busy cleared", {6'd0, l_busy, r_busy}, 8'd0);
    read_both(TA[5], 8'h99, "R1 winner write");

    // R7 write/write tie: left wins
    set_port(1'b0, OP_WR, TA[6], 8'h11);
    set_port(1'b1, OP_WR, TA[6], 8'h22);
    tick();
    chk("R7 tie r_busy", {7'd0, r_busy}, 8'd1);
    idle();
    tick();
    read_both(TA[6], 8'h11, "R7 right write dropped");

    // R8 right arrives first and holds; left newcomer loses
    set_port(1'b1, OP_WR, TA[7], 8'h33);
    tick();
    set_port(1'b0, OP_WR, TA[7], 8'h44);
    tick();
    chk("R8 l_busy", {7'd0, l_busy}, 8'd1);
    chk("R8 r_busy", {7'd0, r_busy}, 8'd0);
    tick();
    chk("R8 l_busy held", {7'd0, l_busy}, 8'd1);
    idle();
    tick();
    chk("R9 cleared after hold", {6'd0, l_busy, r_busy}, 8'd0);
    read_both(TA[7], 8'h33, "R8 left write dropped");

    // R9 different addresses: no busy
    set_port(1'b0, OP_WR, TA[0], 8'h01);
    set_port(1'b1, OP_WR, TA[1], 8'h02);
    tick();
    chk("R9 diff addr busy", {6'd0, l_busy, r_busy}, 8'd0);
    idle();
    tick();
    read_both(TA[1], 8'h02, "R9 right write kept");

    // R10 slave mode
    master = 1'b0;
    r_busy_in = 1'b1;
    set_port(1'b0, OP_WR, TA[2], 8'h55);
    set_port(1'b1, OP_WR, TA[2], 8'h66);
    tick();
    chk("R10 slave busy", {6'd0, l_busy, r_busy}, 8'd0);
    idle();
    r_busy_in = 1'b0;
    tick();
    read_both(TA[2], 8'h55, "R10 busy_in blocks right");
    l_busy_in = 1'b1;
    set_port(1'b0, OP_WR, TA[4], 8'h77);
    tick();
    idle();
    l_busy_in = 1'b0;
    tick();
    read_both(TA[4], TD[4], "R10 busy_in blocks left");
    set_port(1'b1, OP_WR, TA[4], 8'h78);
    tick();
    idle();
    tick();
    read_both(TA[4], 8'h78, "R10 write allowed");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule